// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block is the slave-side command gate for the status register of a serial flash. It watches a chip-select, serial clock and serial data-in line, collects each command frame MSB first, and acts on it only when chip-select returns high. Two opcodes arm the register: an enable-for-status-write command and a general write-enable command. A status-write command that directly follows an arming frame loads new block-protect bits and a lock bit. Any other frame in between clears the arming.

A write-protect input works together with the lock bit. When the pin is low and the lock bit is set, the register is frozen and status writes are dropped. When the pin is high, or the lock is clear, every writable bit may change in one write, including setting the lock. The SPI pins are sampled in the system clock domain, which must run several times faster than the serial clock.

Top module: `spi_status_guard`

## Requirements
- R1: After reset, `status` reads 0x3C (bits 5..2 set, every other bit 0), `armed` is 0 and `wr_ok` is 0.
- R2: Data bits are captured on rising serial-clock edges while chip-select is low, MSB first. Frames sent with the clock idling low (mode 0) or idling high (mode 3) decode the same way.
- R3: A frame of exactly 8 clocks holding opcode 0x50 or 0x06 sets `armed` when chip-select rises.
- R4: A frame of exactly 16 clocks, opcode 0x01 followed by a data byte, completed while armed and not locked, copies data bits 7 and 5..2 into `status` and pulses `wr_ok` for one cycle. Bits 6, 1 and 0 stay 0.
- R5: A status-write frame that arrives while not armed leaves `status` unchanged and gives no `wr_ok` pulse.
- R6: Every completed frame other than a valid arming frame clears `armed`. This includes other opcodes and frames of the wrong length (for example 7, 9, 15 or 17 clocks), and such frames leave `status` unchanged.
- R7: If `wp_n` is low and status bit 7 (lock) is 1 when a status write completes, the write is ignored, `wr_ok` stays low and `armed` is cleared.
- R8: If `wp_n` is low and the lock is 0, one write may set the lock and change bits 5..2 together.
- R9: If `wp_n` is high, a write may clear the lock bit that is currently set.
- R10: `status` changes only in the cycle after the synchronized chip-select rises at the end of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect, active low |
| status | output | 8 | Status register: bit 7 lock, bits 5..2 protect |
| armed | output | 1 | A status write would currently be accepted |
| wr_ok | output | 1 | One-cycle pulse when a status write is applied |

## Verification
The bench targets the lock corner: `wp_n` low with the lock set. A design that tested the pin alone, or the lock alone, would let that write through or would wrongly refuse a write that sets the lock. It sends frames one clock short and one clock long around both valid lengths. A counter that ignores length would arm or write on a truncated frame. It places a foreign opcode between arm and write to catch a design that never clears `armed`. It also repeats frames in both clock modes, which exposes a design that samples on the wrong edge or mishandles the mode-3 idle level.

// File: rtl/spi_status_guard.sv
module spi_status_guard #(
  parameter logic [7:0] OP_ARM_SR = 8'h50,
  parameter logic [7:0] OP_ARM_WE = 8'h06,
  parameter logic [7:0] OP_WR_SR  = 8'h01,
  parameter logic [7:0] RST_VAL   = 8'h3C,
  parameter int         CMD_BITS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  input  logic       wp_n,
  output logic [7:0] status,
  output logic       armed,
  output logic       wr_ok
);
  localparam int         FRAME_BITS = 2 * CMD_BITS;
  localparam int         CW         = $clog2(FRAME_BITS + 2) + 1;
  localparam logic [CW-1:0] CMAX    = '1;
  localparam logic [7:0] WMASK      = 8'hBC;
  localparam logic [7:0] LOCK_BIT   = 8'h80;

  logic          cs_q, cs_d, sck_q, sck_d, mosi_q, wp_q;
  logic [CW-1:0] cnt;
  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 1'b1; cs_d <= 1'b1; sck_q <= 1'b0; sck_d <= 1'b0;
      mosi_q <= 1'b0; wp_q <= 1'b1;
    end else begin
      cs_q <= spi_cs_n; cs_d <= cs_q; sck_q <= spi_sck; sck_d <= sck_q;
      mosi_q <= spi_mosi; wp_q <= wp_n;
    end

  wire sck_rise = sck_q & ~sck_d & ~cs_q;
  wire cs_rise  = cs_q & ~cs_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; shreg <= '0;
    end else if (cs_rise) begin
      cnt <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[FRAME_BITS-2:0], mosi_q};
      if (cnt != CMAX) cnt <= cnt + 1'b1;
    end

  wire [7:0] short_op = shreg[CMD_BITS-1:0];
  wire [7:0] long_op  = shreg[FRAME_BITS-1:CMD_BITS];
  wire [7:0] wdata    = shreg[CMD_BITS-1:0];
  wire arm_hit  = cs_rise && cnt == CW'(CMD_BITS) &&
                  (short_op == OP_ARM_SR || short_op == OP_ARM_WE);
  wire wr_frame = cs_rise && armed && cnt == CW'(FRAME_BITS) && long_op == OP_WR_SR;
  wire locked   = ~wp_q & status[7];
  wire wr_go    = wr_frame & ~locked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status <= RST_VAL; armed <= 1'b0; wr_ok <= 1'b0;
    end else begin
      wr_ok <= wr_go;
      if (cs_rise) armed <= arm_hit;
      if (wr_go) status <= (status & ~WMASK) | (wdata & WMASK);
    end

  a_r1_ro_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~WMASK) == 8'h00);
  a_r7_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (~wp_q && (status & LOCK_BIT) != 8'h00) |=> $stable(status));
  a_r10_change_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> $past(cs_rise));
  a_r3_arm_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(cs_rise));
  a_r4_ok_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> !armed);
endmodule

// File: tb/tb_spi_status_guard.sv
module tb_spi_status_guard;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0, wp_n = 1;
  logic [7:0] status;
  logic armed, wr_ok;
  int errors = 0, checks = 0;
  logic [7:0] e_status = 8'h3C;
  logic e_armed = 0, e_ok = 0;
  string req = "R1";
  bit running = 0;

  always #4 clk = ~clk;

  spi_status_guard dut (.clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_mosi(mosi), .wp_n(wp_n), .status(status), .armed(armed), .wr_ok(wr_ok));

  always @(negedge clk) if (running) begin
    checks += 3;
    if (status !== e_status) begin errors++;
      $display("FAIL %s status actual=%h expected=%h", req, status, e_status); end
    if (armed !== e_armed) begin errors++;
      $display("FAIL %s armed actual=%b expected=%b", req, armed, e_armed); end
    if (wr_ok !== e_ok) begin errors++;
      $display("FAIL %s wr_ok actual=%b expected=%b", req, wr_ok, e_ok); end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(bit mode3, int nbits, logic [31:0] val);
    bit ok;
    sck = mode3; wait_clk(3);
    cs_n = 0; wait_clk(3);
    for (int i = nbits - 1; i >= 0; i--) begin
      sck = 0; mosi = val[i]; wait_clk(3);
      sck = 1; wait_clk(3);
    end
    sck = mode3; wait_clk(3);
    cs_n = 1;
    ok = 0;
    @(posedge clk); @(posedge clk); #1;
    if (nbits == 8 && (val[7:0] == 8'h50 || val[7:0] == 8'h06)) e_armed = 1;
    else begin
      if (nbits == 16 && val[15:8] == 8'h01 && e_armed && !(!wp_n && e_status[7])) begin
        e_status = val[7:0] & 8'hBC; ok = 1;
      end
      e_armed = 0;
    end
    e_ok = ok;
    @(posedge clk); #1 e_ok = 0;
    wait_clk(3);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1; running = 1;
    req = "R1"; wait_clk(4);
    req = "R5"; frame(0, 16, 16'h0100);
    req = "R3 R4"; frame(0, 8, 8'h06); frame(0, 16, 16'h0100);
    req = "R2 R3 R4"; frame(1, 8, 8'h50); frame(1, 16, 16'h01FF);
    req = "R9"; frame(0, 8, 8'h50); frame(0, 16, 16'h0100);
    req = "R8"; wp_n = 0; wait_clk(4);
    frame(0, 8, 8'h06); frame(0, 16, 16'h01A4);
    req = "R7"; frame(1, 8, 8'h50); frame(1, 16, 16'h0100);
    frame(0, 8, 8'h06); frame(0, 16, 16'h01FF);
    req = "R9"; wp_n = 1; wait_clk(4);
    frame(0, 8, 8'h06); frame(0, 16, 16'h0100);
    req = "R6"; frame(0, 8, 8'h50); frame(0, 8, 8'h05); frame(0, 16, 16'h01BC);
    frame(0, 7, 7'h50); frame(0, 16, 16'h01BC);
    frame(1, 9, 9'h0A0); frame(1, 16, 16'h01BC);
    frame(0, 8, 8'h06); frame(0, 15, 15'h00BC); frame(0, 16, 16'h01BC);
    frame(0, 8, 8'h06); frame(0, 17, 17'h003BC); frame(0, 16, 16'h01BC);
    frame(0, 8, 8'h06); frame(0, 16, 16'h02BC);
    req = "R3"; frame(1, 8, 8'h06); frame(1, 8, 8'h50); frame(1, 16, 16'h0198);
    req = "R2"; frame(1, 8, 8'h06); frame(1, 16, 16'h0124);
    frame(0, 8, 8'h50); frame(0, 16, 16'h0118);
    req = "R10"; wait_clk(5);
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule